// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block sits on the memory side of a cache-coherent system. For every line address it keeps a directory entry and the line's data. The directory entry records either a set of caches that may hold read-only copies, or the single cache that holds a writable copy. Caches send it requests for shared or exclusive access. When a request conflicts with copies held elsewhere, the block moves the entry into a transient recall state and calls those copies back. It then waits for the answers and serves the original request afterwards.

Requests and replies reach the block on two separate inputs. Requests come from the head of a request queue, and the block pops that head only when the request has been fully served. A request that needs a recall stays at the head while the recall runs, and it is evaluated again once the entry is stable. Replies (invalidate acknowledgements, writebacks and flushes) are taken in the cycle they are presented. Replies always win over requests. The block sends one message per cycle on its output. An invalidate that must reach several sharers is sent as a series of single-destination messages, one per cycle, in ascending cache-id order.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every entry is read-shared with an empty sharer set and holds data 0, and out_valid is low.
- R2: A shared request (req_cmd=0) to a read-shared entry adds the requester to the sharer set and pops the request. In the next cycle it sends a shared grant (out_cmd=0) to the requester carrying the stored data.
- R3: A shared request to an entry owned by a different cache does not pop the request. It marks the entry as under owner recall and, in the next cycle, sends a writeback call (out_cmd=2) to the owner.
- R4: An exclusive request (req_cmd=1) to a read-shared entry whose sharer set holds no cache other than the requester pops the request. It makes the requester the owner and, in the next cycle, sends an exclusive grant (out_cmd=1) with the stored data.
- R5: An exclusive request to a read-shared entry with other sharers does not pop the request. The entry moves to sharer recall with the set minus the requester. Invalidate calls (out_cmd=3) then go to each remaining sharer, one per cycle, in ascending id order, and no request is popped while they are being sent.
- R6: An exclusive request to an entry owned by a different cache does not pop the request. It marks the entry as under owner recall and, in the next cycle, sends a flush call (out_cmd=4) to the owner.
- R7: An invalidate acknowledgement (rep_cmd=0) removes its sender from the sharer set of a read-shared entry or of an entry under sharer recall. A sharer recall whose set becomes empty returns the entry to read-shared.
- R8: A writeback reply (rep_cmd=1) stores rep_data and leaves the entry read-shared with only the sender. A flush reply (rep_cmd=2) stores rep_data and leaves the entry read-shared with an empty set.
- R9: While the entry addressed by the head request is under recall, the block sends nothing and does not pop. Once the entry is stable again, the held request is served by R2 to R6 using the updated state and data.
- R10: A reply presented together with a request is applied first, and the request waits at least one cycle. Replies produce no output message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request queue head is present |
| req_cmd | input | 1 | 0 shared request, 1 exclusive request |
| req_src | input | ID_W | Requesting cache id |
| req_addr | input | ADDR_W | Requested line address |
| req_pop | output | 1 | Head request is consumed at this clock edge |
| rep_valid | input | 1 | A reply is presented this cycle |
| rep_cmd | input | 2 | 0 invalidate ack, 1 writeback, 2 flush |
| rep_src | input | ID_W | Replying cache id |
| rep_addr | input | ADDR_W | Line address of the reply |
| rep_data | input | DATA_W | Line data for writeback and flush |
| out_valid | output | 1 | Output message valid |
| out_cmd | output | 3 | 0 shared grant, 1 exclusive grant, 2 writeback call, 3 invalidate call, 4 flush call |
| out_dst | output | ID_W | Destination cache id |
| out_addr | output | ADDR_W | Line address |
| out_data | output | DATA_W | Line data, meaningful on grants |

## Verification
The assertions assume an environment that behaves as a coherent set of caches. A writeback or flush reply comes only from the cache the directory names as owner. An invalidate acknowledgement comes only from a listed sharer. The request head stays stable until it is popped, and the output is always accepted. The stimulus follows these rules: every reply the bench injects either answers a recall that the bench has just seen issued, or is a voluntary release of a copy that the earlier steps granted to that same cache. No encoding outside those listed in the requirements is ever driven.

// File: rtl/coh_home_pkg.sv
package coh_home_pkg;

  typedef enum logic [1:0] {
    DS_SHARED    = 2'd0,
    DS_OWNED     = 2'd1,
    DS_RECALL_SH = 2'd2,
    DS_RECALL_OW = 2'd3
  } dir_mode_e;

  typedef enum logic [2:0] {
    OC_SH_GRANT   = 3'd0,
    OC_EX_GRANT   = 3'd1,
    OC_WB_CALL    = 3'd2,
    OC_INV_CALL   = 3'd3,
    OC_FLUSH_CALL = 3'd4
  } out_cmd_e;

  typedef enum logic [1:0] {
    RC_INV_ACK    = 2'd0,
    RC_WB_DATA    = 2'd1,
    RC_FLUSH_DATA = 2'd2,
    RC_UNUSED     = 2'd3
  } rep_cmd_e;

  localparam logic REQ_SHARED = 1'b0;
  localparam logic REQ_EXCL   = 1'b1;

endpackage

// File: rtl/coh_low_pick.sv
module coh_low_pick #(
  parameter int N_CACHE = 8,
  localparam int ID_W = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
  input  logic [N_CACHE-1:0] vec,
  output logic [ID_W-1:0]    idx,
  output logic               found
);

  // Scan from the top so the lowest set bit is assigned last and wins.
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = N_CACHE - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = ID_W'(i);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/coh_dir_store.sv
module coh_dir_store
  import coh_home_pkg::*;
#(
  parameter int N_CACHE = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output dir_mode_e         rd_mode,
  output logic [N_CACHE-1:0] rd_vec,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  dir_mode_e         wr_mode,
  input  logic [N_CACHE-1:0] wr_vec,
  input  logic [DATA_W-1:0] wr_data
);

  dir_mode_e          mode_q [DEPTH];
  logic [N_CACHE-1:0] vec_q  [DEPTH];
  logic [DATA_W-1:0]  data_q [DEPTH];

  assign rd_mode = mode_q[rd_addr];
  assign rd_vec  = vec_q[rd_addr];
  assign rd_data = data_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mode_q[i] <= DS_SHARED;
        vec_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (we) begin
      mode_q[wr_addr] <= wr_mode;
      vec_q[wr_addr]  <= wr_vec;
      data_q[wr_addr] <= wr_data;
    end
  end

  // R4
  owner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wr_mode == DS_OWNED || wr_mode == DS_RECALL_OW)) |-> $onehot(wr_vec));

endmodule

// File: rtl/coh_inv_mcast.sv
module coh_inv_mcast #(
  parameter int N_CACHE = 8,
  parameter int ADDR_W  = 4,
  localparam int ID_W = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [N_CACHE-1:0] load_vec,
  input  logic [ADDR_W-1:0]  load_addr,
  output logic               busy,
  output logic [ID_W-1:0]    dst,
  output logic [ADDR_W-1:0]  addr
);

  logic [N_CACHE-1:0] mask_q, mask_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [N_CACHE-1:0] clr_bit;

  coh_low_pick #(.N_CACHE(N_CACHE)) u_pick (
    .vec   (mask_q),
    .idx   (dst),
    .found (busy)
  );

  always_comb begin
    clr_bit      = '0;
    clr_bit[dst] = busy;
    mask_d       = mask_q;
    addr_d       = addr_q;
    if (load) begin
      mask_d = load_vec;
      addr_d = load_addr;
    end else if (busy) begin
      mask_d = mask_q & ~clr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      addr_q <= '0;
    end else begin
      mask_q <= mask_d;
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

  // R5
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  // R5
  mask_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((mask_q & ~$past(mask_q)) == '0));

endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
  import coh_home_pkg::*;
#(
  parameter int N_CACHE = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  localparam int ID_W = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_cmd,
  input  logic [ID_W-1:0]   req_src,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_pop,
  input  logic              rep_valid,
  input  logic [1:0]        rep_cmd,
  input  logic [ID_W-1:0]   rep_src,
  input  logic [ADDR_W-1:0] rep_addr,
  input  logic [DATA_W-1:0] rep_data,
  output logic              out_valid,
  output logic [2:0]        out_cmd,
  output logic [ID_W-1:0]   out_dst,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);

  // Directory access
  logic [ADDR_W-1:0]  rd_addr;
  dir_mode_e          rd_mode;
  logic [N_CACHE-1:0] rd_vec;
  logic [DATA_W-1:0]  rd_data;
  logic               wr_en;
  dir_mode_e          wr_mode;
  logic [N_CACHE-1:0] wr_vec;
  logic [DATA_W-1:0]  wr_data;

  // Multicast sequencer
  logic               mc_load;
  logic [N_CACHE-1:0] mc_vec;
  logic               mc_busy;
  logic [ID_W-1:0]    mc_dst;
  logic [ADDR_W-1:0]  mc_addr;

  // Owner lookup and id masks
  logic [ID_W-1:0]    own_idx;
  logic               own_found;
  logic [N_CACHE-1:0] req_bit, rep_bit, others, shrunk;

  // Output message, next value
  logic               o_valid_d;
  out_cmd_e           o_cmd_d;
  logic [ID_W-1:0]    o_dst_d;
  logic [ADDR_W-1:0]  o_addr_d;
  logic [DATA_W-1:0]  o_data_d;

  // Decision from the directory path, before the multicast override
  logic               dec_valid;
  out_cmd_e           dec_cmd;
  logic [ID_W-1:0]    dec_dst;

  assign rd_addr = rep_valid ? rep_addr : req_addr;

  coh_dir_store #(
    .N_CACHE (N_CACHE),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_mode (rd_mode),
    .rd_vec  (rd_vec),
    .rd_data (rd_data),
    .we      (wr_en),
    .wr_addr (rd_addr),
    .wr_mode (wr_mode),
    .wr_vec  (wr_vec),
    .wr_data (wr_data)
  );

  coh_low_pick #(.N_CACHE(N_CACHE)) u_owner (
    .vec   (rd_vec),
    .idx   (own_idx),
    .found (own_found)
  );

  coh_inv_mcast #(
    .N_CACHE (N_CACHE),
    .ADDR_W  (ADDR_W)
  ) u_mcast (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (mc_load),
    .load_vec  (mc_vec),
    .load_addr (req_addr),
    .busy      (mc_busy),
    .dst       (mc_dst),
    .addr      (mc_addr)
  );

  always_comb begin
    req_bit          = '0;
    req_bit[req_src] = 1'b1;
    rep_bit          = '0;
    rep_bit[rep_src] = 1'b1;
    others           = rd_vec & ~req_bit;
    shrunk           = rd_vec & ~rep_bit;
  end

  // Next-state decision: replies first, then the head request.
  always_comb begin
    wr_en     = 1'b0;
    wr_mode   = rd_mode;
    wr_vec    = rd_vec;
    wr_data   = rd_data;
    req_pop   = 1'b0;
    mc_load   = 1'b0;
    mc_vec    = '0;
    dec_valid = 1'b0;
    dec_cmd   = OC_SH_GRANT;
    dec_dst   = req_src;

    if (rep_valid) begin
      unique case (rep_cmd_e'(rep_cmd))
        RC_INV_ACK: begin
          if (rd_mode == DS_SHARED || rd_mode == DS_RECALL_SH) begin
            wr_en   = 1'b1;
            wr_vec  = shrunk;
            wr_mode = (shrunk == '0) ? DS_SHARED : rd_mode;
          end
        end
        RC_WB_DATA: begin
          wr_en   = 1'b1;
          wr_mode = DS_SHARED;
          wr_vec  = rep_bit;
          wr_data = rep_data;
        end
        RC_FLUSH_DATA: begin
          wr_en   = 1'b1;
          wr_mode = DS_SHARED;
          wr_vec  = '0;
          wr_data = rep_data;
        end
        default: ;
      endcase
    end else if (req_valid && !mc_busy) begin
      unique case (rd_mode)
        DS_SHARED: begin
          if (req_cmd == REQ_SHARED) begin
            wr_en     = 1'b1;
            wr_vec    = rd_vec | req_bit;
            req_pop   = 1'b1;
            dec_valid = 1'b1;
            dec_cmd   = OC_SH_GRANT;
          end else if (others == '0) begin
            wr_en     = 1'b1;
            wr_mode   = DS_OWNED;
            wr_vec    = req_bit;
            req_pop   = 1'b1;
            dec_valid = 1'b1;
            dec_cmd   = OC_EX_GRANT;
          end else begin
            wr_en   = 1'b1;
            wr_mode = DS_RECALL_SH;
            wr_vec  = others;
            mc_load = 1'b1;
            mc_vec  = others;
          end
        end
        DS_OWNED: begin
          if (rd_vec[req_src] || !own_found) begin
            // The owner asks again: serve it directly.
            wr_en     = 1'b1;
            wr_mode   = (req_cmd == REQ_SHARED) ? DS_SHARED : DS_OWNED;
            wr_vec    = req_bit;
            req_pop   = 1'b1;
            dec_valid = 1'b1;
            dec_cmd   = (req_cmd == REQ_SHARED) ? OC_SH_GRANT : OC_EX_GRANT;
          end else begin
            wr_en     = 1'b1;
            wr_mode   = DS_RECALL_OW;
            dec_valid = 1'b1;
            dec_dst   = own_idx;
            dec_cmd   = (req_cmd == REQ_SHARED) ? OC_WB_CALL : OC_FLUSH_CALL;
          end
        end
        default: ;  // recall in progress: hold the head request
      endcase
    end
  end

  always_comb begin
    if (mc_busy) begin
      o_valid_d = 1'b1;
      o_cmd_d   = OC_INV_CALL;
      o_dst_d   = mc_dst;
      o_addr_d  = mc_addr;
      o_data_d  = '0;
    end else begin
      o_valid_d = dec_valid;
      o_cmd_d   = dec_cmd;
      o_dst_d   = dec_dst;
      o_addr_d  = req_addr;
      o_data_d  = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cmd   <= '0;
      out_dst   <= '0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= o_valid_d;
      if (o_valid_d) begin
        out_cmd  <= o_cmd_d;
        out_dst  <= o_dst_d;
        out_addr <= o_addr_d;
        out_data <= o_data_d;
      end
    end
  end

  // R10
  rep_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> !req_pop);

  // R2
  pop_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pop |=> (out_valid && (out_cmd == OC_SH_GRANT || out_cmd == OC_EX_GRANT)));

  // R5
  mc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mc_busy |-> !req_pop);

  // R10
  rep_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && !mc_busy) |=> !out_valid);

endmodule

// File: tb/test_coh_home_dir.sv
module test_coh_home_dir;

  localparam int N  = 8;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int IW = 3;

  localparam logic [2:0] SHG = 3'd0, EXG = 3'd1, WBC = 3'd2, INVC = 3'd3, FLC = 3'd4;
  localparam logic [1:0] ACK = 2'd0, WBD = 2'd1, FLD = 2'd2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_cmd;
  logic [IW-1:0] req_src;
  logic [AW-1:0] req_addr;
  logic          req_pop;
  logic          rep_valid;
  logic [1:0]    rep_cmd;
  logic [IW-1:0] rep_src;
  logic [AW-1:0] rep_addr;
  logic [DW-1:0] rep_data;
  logic          out_valid;
  logic [2:0]    out_cmd;
  logic [IW-1:0] out_dst;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  coh_home_dir #(.N_CACHE(N), .ADDR_W(AW), .DATA_W(DW)) i_coh_home_dir (
    .clk, .rst_n, .req_valid, .req_cmd, .req_src, .req_addr, .req_pop,
    .rep_valid, .rep_cmd, .rep_src, .rep_addr, .rep_data,
    .out_valid, .out_cmd, .out_dst, .out_addr, .out_data
  );

  typedef struct {
    logic [2:0]    cmd;
    logic [IW-1:0] dst;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    bit            use_data;
    string         tag;
  } exp_t;

  exp_t expq[$];
  int   n_chk = 0;
  int   n_err = 0;
  int   out_seen = 0;

  task automatic want(input logic [2:0] c, input int d, input int a,
                      input logic [DW-1:0] v, input bit ud, input string tag);
    exp_t e;
    e.cmd = c; e.dst = IW'(d); e.addr = AW'(a); e.data = v; e.use_data = ud; e.tag = tag;
    expq.push_back(e);
  endtask

  // Monitor: compare each produced message with the scoreboard head.
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && out_valid) begin
      out_seen++;
      n_chk++;
      if (expq.size() == 0) begin
        n_err++;
        $display("FAIL unexpected message: cmd=%0d dst=%0d addr=%0d expected none", out_cmd, out_dst, out_addr);
      end else begin
        e = expq.pop_front();
        if (out_cmd !== e.cmd || out_dst !== e.dst || out_addr !== e.addr ||
            (e.use_data && out_data !== e.data)) begin
          n_err++;
          $display("FAIL %s: got cmd=%0d dst=%0d addr=%0d data=%h, expected cmd=%0d dst=%0d addr=%0d data=%h",
                   e.tag, out_cmd, out_dst, out_addr, out_data, e.cmd, e.dst, e.addr, e.data);
        end
      end
    end
  end

  task automatic do_req(input logic ex, input int src, input int addr);
    bit got;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = ex; req_src = IW'(src); req_addr = AW'(addr);
    got = 1'b0;
    while (!got) begin
      #5;
      got = req_pop;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic do_rep(input logic [1:0] c, input int src, input int addr, input logic [DW-1:0] v);
    @(negedge clk);
    rep_valid = 1'b1; rep_cmd = c; rep_src = IW'(src); rep_addr = AW'(addr); rep_data = v;
    @(negedge clk);
    rep_valid = 1'b0;
  endtask

  // No message at all for n cycles.
  task automatic quiet(input int n, input string tag);
    int s;
    #2;
    s = out_seen;
    repeat (n) @(negedge clk);
    #2;
    n_chk++;
    if (out_seen != s) begin
      n_err++;
      $display("FAIL %s: %0d messages while held, expected 0", tag, out_seen - s);
    end
  endtask

  task automatic drain(input string tag);
    repeat (4) @(negedge clk);
    #2;
    n_chk++;
    if (expq.size() != 0) begin
      n_err++;
      $display("FAIL %s: %0d expected messages missing, expected 0", tag, expq.size());
      expq.delete();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R9: run did not finish, got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_cmd = 1'b0; req_src = '0; req_addr = '0;
    rep_valid = 1'b0; rep_cmd = '0; rep_src = '0; rep_addr = '0; rep_data = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_err++;
      $display("FAIL R1: out_valid=%b during reset, expected 0", out_valid);
    end
    rst_n = 1'b1;
    quiet(3, "R1 idle after reset");

    // R1 data zero, R2 shared grants to a growing sharer set
    want(SHG, 1, 5, 32'h0, 1, "R1/R2 first sharer");
    do_req(1'b0, 1, 5);
    want(SHG, 2, 5, 32'h0, 1, "R2 second sharer");
    do_req(1'b0, 2, 5);
    drain("R2");

    // R4 exclusive on an empty entry
    want(EXG, 0, 2, 32'h0, 1, "R4 empty entry");
    do_req(1'b1, 0, 2);
    drain("R4");

    // R3 writeback recall then R9 replay with written-back data
    want(WBC, 0, 2, 32'h0, 0, "R3 writeback call");
    want(SHG, 3, 2, 32'hAAAA_5555, 1, "R9/R8 replay after writeback");
    fork
      do_req(1'b0, 3, 2);
      begin
        repeat (3) @(negedge clk);
        quiet(3, "R9 held during owner recall");
        do_rep(WBD, 0, 2, 32'hAAAA_5555);
      end
    join
    drain("R3");

    // R5 multicast to sharers 1 and 2, R7 acks, R9 replay
    want(INVC, 1, 5, 32'h0, 0, "R5 invalidate sharer 1");
    want(INVC, 2, 5, 32'h0, 0, "R5 invalidate sharer 2");
    want(EXG, 6, 5, 32'h0, 1, "R9 replay after sharer recall");
    fork
      do_req(1'b1, 6, 5);
      begin
        repeat (6) @(negedge clk);
        do_rep(ACK, 2, 5, 32'h0);
        quiet(3, "R7 one sharer still left");
        do_rep(ACK, 1, 5, 32'h0);
      end
    join
    drain("R5");

    // R6 flush recall
    want(FLC, 6, 5, 32'h0, 0, "R6 flush call");
    want(EXG, 4, 5, 32'h0000_1234, 1, "R8/R9 replay after flush");
    fork
      do_req(1'b1, 4, 5);
      begin
        repeat (4) @(negedge clk);
        do_rep(FLD, 6, 5, 32'h0000_1234);
      end
    join
    drain("R6");

    // R5 requester among sharers: addr 2 holds {0,3}, exclusive from 3 calls only 0
    want(INVC, 0, 2, 32'h0, 0, "R5 requester excluded");
    want(EXG, 3, 2, 32'hAAAA_5555, 1, "R7 empty recall returns to shared");
    fork
      do_req(1'b1, 3, 2);
      begin
        repeat (4) @(negedge clk);
        do_rep(ACK, 0, 2, 32'h0);
      end
    join
    drain("R5b");

    // R4 requester is the only sharer
    want(SHG, 7, 9, 32'h0, 1, "R2 sharer 7");
    do_req(1'b0, 7, 9);
    want(EXG, 7, 9, 32'h0, 1, "R4 only the requester shares");
    do_req(1'b1, 7, 9);
    drain("R4b");

    // R10 reply and request together; R7 ack in stable shared state
    want(SHG, 1, 12, 32'h0, 1, "R2 sharer 1");
    do_req(1'b0, 1, 12);
    want(SHG, 5, 12, 32'h0, 1, "R2 sharer 5");
    do_req(1'b0, 5, 12);
    want(EXG, 5, 12, 32'h0, 1, "R10 reply applied before request");
    fork
      do_req(1'b1, 5, 12);
      do_rep(ACK, 1, 12, 32'h0);
    join
    drain("R10");

    // R5 ascending order 0,4,7 regardless of join order; acks out of order
    want(SHG, 7, 7, 32'h0, 1, "R2 sharer 7");
    do_req(1'b0, 7, 7);
    want(SHG, 0, 7, 32'h0, 1, "R2 sharer 0");
    do_req(1'b0, 0, 7);
    want(SHG, 4, 7, 32'h0, 1, "R2 sharer 4");
    do_req(1'b0, 4, 7);
    want(INVC, 0, 7, 32'h0, 0, "R5 ascending first");
    want(INVC, 4, 7, 32'h0, 0, "R5 ascending second");
    want(INVC, 7, 7, 32'h0, 0, "R5 ascending third");
    want(EXG, 2, 7, 32'h0, 1, "R9 replay after three acks");
    fork
      do_req(1'b1, 2, 7);
      begin
        repeat (6) @(negedge clk);
        do_rep(ACK, 7, 7, 32'h0);
        do_rep(ACK, 0, 7, 32'h0);
        quiet(2, "R9 held with sharer 4 left");
        do_rep(ACK, 4, 7, 32'h0);
      end
    join
    drain("R5c");

    // R8 voluntary writeback: addr 5 owned by 4
    do_rep(WBD, 4, 5, 32'h0000_0055);
    quiet(2, "R10 reply makes no message");
    want(SHG, 1, 5, 32'h0000_0055, 1, "R8 writeback leaves shared, data stored");
    do_req(1'b0, 1, 5);
    // sharers now {1,4}: exclusive from 1 must call only 4
    want(INVC, 4, 5, 32'h0, 0, "R8 writer kept as sharer");
    want(EXG, 1, 5, 32'h0000_0055, 1, "R9 replay");
    fork
      do_req(1'b1, 1, 5);
      begin
        repeat (4) @(negedge clk);
        do_rep(ACK, 4, 5, 32'h0);
      end
    join
    drain("R8");

    // R8 voluntary flush: addr 2 owned by 3
    do_rep(FLD, 3, 2, 32'h0000_0077);
    want(EXG, 1, 2, 32'h0000_0077, 1, "R8 flush leaves empty set, data stored");
    do_req(1'b1, 1, 2);
    drain("R8b");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule